// File: doc/BRIEF.md
# Interpolating Quarter-Wave Sine Generator

This block turns a phase word into a signed sine sample once per clock. Only one quarter of the wave is stored. The stored quarter is a 256-entry table of unsigned amplitudes, together with a companion table of slopes, where each slope is the step from one entry to the next. The low bits of the phase act as a fraction. A narrow multiplier scales the slope by this fraction, and the result is added to the table entry, so the output is a straight-line interpolation between neighbouring samples. Both tables are computed as constants when the design is elaborated, so no memory has to be initialised.

The quadrant bits of the phase decide two things. In the second and fourth quarters of the cycle, the index and fraction are mirrored, which walks the stored quarter backwards. In the second half of the cycle, the result is negated.

The usual source of the phase is an accumulator that adds a frequency word every cycle. A phase sample and its `in_valid` strobe go through three register stages:

- **fold**: quadrant decode and mirroring.
- **fetch**: table read and slope-times-fraction product.
- **emit**: sum and sign.

The sample leaves the block with `out_valid`.

Top module: `sine_interp_gen`

## Requirements
- R1: `phase[17:16]` is the quadrant, `phase[15:8]` is the table index i, and `phase[7:0]` is the fraction f. Together, i and f form the 16-bit field.
- R2: When the quadrant is 0 and f = 0, `sample` equals T[i] = round(2^18 · sin(π/2 · i/256)).
- R3: In quadrant 0, the magnitude is T[i] + floor(D[i] · f / 256). Here D[i] = T[i+1] − T[i], and T[256] is taken as 2^18.
- R4: In quadrants 1 and 3, the 16-bit field is bit-inverted before it is split into i and f. After that, R3 applies unchanged.
- R5: In quadrants 2 and 3, `sample` is the two's-complement negation of the magnitude. In quadrants 0 and 1, `sample` is the magnitude itself. `sample` is never negative when `phase[17]` is 0.
- R6: The magnitude never reaches 2^18. As a result, `sample` stays within ±(2^18 − 1) and never takes the value −2^18.
- R7: Each phase accepted with `in_valid` high produces `out_valid` high exactly 3 clock edges later, and the samples come out in order. On cycles where `out_valid` is low, `sample` keeps its previous value.
- R8: While `rst_n` is low, `out_valid` is 0 and `sample` is 0.
- R9: Every sample lies within 3 LSB of ±2^18 · sin(π/2 · r/65536). Here r is the 16-bit field after the mirroring of R4, and the sign follows R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Phase word is present this cycle |
| phase | input | 18 | Phase word: quadrant, index, fraction |
| out_valid | output | 1 | `sample` carries a new result |
| sample | output | 19 | Signed sine sample, two's complement |

## Verification
The checker assumes two things about the inputs: `in_valid` is low throughout reset, and `phase` is a defined value whenever `in_valid` is high. On that basis, the latency, sign and origin properties look back three cycles only after three edges out of reset have passed.

The stimulus follows the same rules. It holds `in_valid` low during reset and the idle gaps, and drives a full phase word on every valid cycle. It covers:
- every table index with a zero fraction;
- each quadrant seam and the last index at its largest fraction;
- a strided sweep of the whole circle;
- an LFSR-driven run with random gaps between valid cycles.

// File: rtl/sine_interp_pkg.sv
package sine_interp_pkg;

    localparam real HALF_PI = 1.5707963267948966;

    // Odd Taylor series, adequate to well below one part in 2^30 over [0, pi/2]
    function automatic real quarter_sin(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n <= 9; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Rounded amplitude of entry k; the entry one past the end is full scale
    function automatic int quarter_entry(input int k, input int idx_w, input int amp_w);
        real x;
        if (k >= (1 << idx_w)) begin
            return (1 << amp_w);
        end
        x = HALF_PI * real'(k) / real'(1 << idx_w);
        return $rtoi(real'(1 << amp_w) * quarter_sin(x) + 0.5);
    endfunction

endpackage

// File: rtl/sine_phase_fold.sv
module sine_phase_fold #(
    parameter int PHASE_W = 18,
    parameter int IDX_W   = 8,
    parameter int FRAC_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PHASE_W-1:0] phase,
    output logic               fold_valid,
    output logic               fold_neg,
    output logic [IDX_W-1:0]   fold_idx,
    output logic [FRAC_W-1:0]  fold_frac
);
    localparam int FIELD_W = IDX_W + FRAC_W;

    logic [FIELD_W-1:0] field_raw;
    logic [FIELD_W-1:0] field_fold;
    logic               mirror;

    always_comb begin
        field_raw  = phase[FIELD_W-1:0];
        mirror     = phase[FIELD_W];
        field_fold = mirror ? ~field_raw : field_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fold_valid <= 1'b0;
            fold_neg   <= 1'b0;
            fold_idx   <= '0;
            fold_frac  <= '0;
        end else begin
            fold_valid <= in_valid;
            if (in_valid) begin
                fold_neg  <= phase[PHASE_W-1];
                fold_idx  <= field_fold[FIELD_W-1:FRAC_W];
                fold_frac <= field_fold[FRAC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/sine_quarter_rom.sv
module sine_quarter_rom #(
    parameter int IDX_W  = 8,
    parameter int AMP_W  = 18,
    parameter int DIFF_W = 11
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [AMP_W-1:0]  base,
    output logic [DIFF_W-1:0] slope
);
    localparam int DEPTH = 1 << IDX_W;

    logic [AMP_W-1:0]  base_tbl  [DEPTH];
    logic [DIFF_W-1:0] slope_tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int VAL_HERE = sine_interp_pkg::quarter_entry(k, IDX_W, AMP_W);
        localparam int VAL_NEXT = sine_interp_pkg::quarter_entry(k + 1, IDX_W, AMP_W);
        assign base_tbl[k]  = AMP_W'(VAL_HERE);
        assign slope_tbl[k] = DIFF_W'(VAL_NEXT - VAL_HERE);
    end

    assign base  = base_tbl[idx];
    assign slope = slope_tbl[idx];
endmodule

// File: rtl/sine_interp_core.sv
module sine_interp_core #(
    parameter int AMP_W  = 18,
    parameter int DIFF_W = 11,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fold_valid,
    input  logic                    fold_neg,
    input  logic [FRAC_W-1:0]       fold_frac,
    input  logic [AMP_W-1:0]        base,
    input  logic [DIFF_W-1:0]       slope,
    output logic                    out_valid,
    output logic signed [AMP_W:0]   sample
);
    localparam int PROD_W = DIFF_W + FRAC_W;
    localparam int OUT_W  = AMP_W + 1;

    logic               fetch_valid;
    logic               fetch_neg;
    logic [AMP_W-1:0]   fetch_base;
    logic [PROD_W-1:0]  fetch_prod;
    logic [AMP_W-1:0]   magnitude;
    logic [OUT_W-1:0]   mag_ext;

    // fetch stage: table values and slope-times-fraction product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
            fetch_neg   <= 1'b0;
            fetch_base  <= '0;
            fetch_prod  <= '0;
        end else begin
            fetch_valid <= fold_valid;
            if (fold_valid) begin
                fetch_neg  <= fold_neg;
                fetch_base <= base;
                fetch_prod <= PROD_W'(slope) * PROD_W'(fold_frac);
            end
        end
    end

    // truncating the scaled product keeps the sum below full scale
    always_comb begin
        magnitude = fetch_base + AMP_W'(fetch_prod >> FRAC_W);
        mag_ext   = {1'b0, magnitude};
    end

    // emit stage: sign application
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sample    <= '0;
        end else begin
            out_valid <= fetch_valid;
            if (fetch_valid) begin
                sample <= fetch_neg ? signed'(~mag_ext + OUT_W'(1)) : signed'(mag_ext);
            end
        end
    end
endmodule

// File: rtl/sine_interp_gen.sv
module sine_interp_gen #(
    parameter int PHASE_W = 18,
    parameter int IDX_W   = 8,
    parameter int FRAC_W  = 8,
    parameter int AMP_W   = 18,
    parameter int DIFF_W  = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [PHASE_W-1:0]    phase,
    output logic                  out_valid,
    output logic signed [AMP_W:0] sample
);
    logic              fold_valid;
    logic              fold_neg;
    logic [IDX_W-1:0]  fold_idx;
    logic [FRAC_W-1:0] fold_frac;
    logic [AMP_W-1:0]  rom_base;
    logic [DIFF_W-1:0] rom_slope;

    sine_phase_fold #(
        .PHASE_W(PHASE_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)
    ) u_fold (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase(phase),
        .fold_valid(fold_valid), .fold_neg(fold_neg),
        .fold_idx(fold_idx), .fold_frac(fold_frac)
    );

    sine_quarter_rom #(
        .IDX_W(IDX_W), .AMP_W(AMP_W), .DIFF_W(DIFF_W)
    ) u_rom (
        .idx(fold_idx), .base(rom_base), .slope(rom_slope)
    );

    sine_interp_core #(
        .AMP_W(AMP_W), .DIFF_W(DIFF_W), .FRAC_W(FRAC_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .fold_valid(fold_valid), .fold_neg(fold_neg),
        .fold_frac(fold_frac), .base(rom_base), .slope(rom_slope),
        .out_valid(out_valid), .sample(sample)
    );
endmodule

// File: rtl/sine_interp_gen_chk.sv
module sine_interp_gen_chk #(
    parameter int PHASE_W = 18,
    parameter int AMP_W   = 18
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [PHASE_W-1:0]    phase,
    input logic                  out_valid,
    input logic signed [AMP_W:0] sample
);
    localparam int OUT_W = AMP_W + 1;

    logic [1:0] edges_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)
            edges_seen <= '0;
        else if (edges_seen != 2'd3)
            edges_seen <= edges_seen + 2'd1;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(sample));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sample != {1'b1, {AMP_W{1'b0}}}));

    p_sign_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_seen == 2'd3 && out_valid && !$past(phase[PHASE_W-1], 3))
            |-> !sample[OUT_W-1]);

    p_origin_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_seen == 2'd3 && out_valid && ($past(phase[PHASE_W-2:0], 3) == '0))
            |-> (sample == '0));
endmodule

bind sine_interp_gen sine_interp_gen_chk #(
    .PHASE_W(PHASE_W), .AMP_W(AMP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase(phase),
    .out_valid(out_valid), .sample(sample)
);

// File: tb/sine_interp_gen_tb_top.sv
module sine_interp_gen_tb_top;
    localparam real PI = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [17:0]        phase = '0;
    logic               out_valid;
    logic signed [18:0] sample;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int tref [0:256];

    int    q_exp [$];
    int    q_cyc [$];
    int    q_ph  [$];
    string q_tag [$];
    int    last_sample = 0;
    bit    finished = 0;

    sine_interp_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase(phase),
        .out_valid(out_valid), .sample(sample)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int folded(input int ph);
        int fld;
        fld = ph & 16'hFFFF;
        if ((ph >> 16) & 1) fld = fld ^ 16'hFFFF;
        return fld;
    endfunction

    // R3/R4/R5 integer model built from the requirement text
    function automatic int model(input int ph);
        int fld, i, f, mag;
        fld = folded(ph);
        i = fld >> 8;
        f = fld & 8'hFF;
        mag = tref[i] + (((tref[i+1] - tref[i]) * f) >> 8);
        return ((ph >> 17) & 1) ? -mag : mag;
    endfunction

    task automatic drive(input int ph, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        phase    = 18'(ph);
        q_exp.push_back(model(ph));
        q_cyc.push_back(cyc);
        q_ph.push_back(ph);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            phase    = 18'h2AAAA;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R7 unexpected output", int'(sample), 0);
                end else begin
                    int e, c, ph, fld;
                    string tg;
                    real rv;
                    e  = q_exp.pop_front();
                    c  = q_cyc.pop_front();
                    ph = q_ph.pop_front();
                    tg = q_tag.pop_front();
                    check(cyc == c + 3, "R7 latency", cyc - c, 3);
                    check(int'(sample) == e, tg, int'(sample), e);
                    check(int'(sample) < 262144 && int'(sample) > -262144, "R6", int'(sample), 0);
                    fld = folded(ph);
                    rv = 262144.0 * $sin(PI / 2.0 * real'(fld) / 65536.0);
                    if ((ph >> 17) & 1) rv = -rv;
                    check((real'(sample) - rv) <= 3.0 && (rv - real'(sample)) <= 3.0,
                          "R9 accuracy", int'(sample), $rtoi(rv));
                end
                last_sample = int'(sample);
            end else begin
                check(int'(sample) == last_sample, "R7 hold while idle", int'(sample), last_sample);
            end
        end
    end

    function automatic string tag_for(input int ph);
        if ((ph >> 17) & 1) return "R5 negation";
        if ((ph >> 16) & 1) return "R4 mirror";
        if ((ph & 8'hFF) == 0) return "R2 table point";
        return "R3 interpolation";
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int k = 0; k <= 256; k++)
            tref[k] = (k == 256) ? 262144 : $rtoi(262144.0 * $sin(PI / 2.0 * real'(k) / 256.0) + 0.5);

        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R8 valid in reset", int'(out_valid), 0);
        check(int'(sample) == 0, "R8 sample in reset", int'(sample), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: every table point in quadrant 0
        for (int i = 0; i < 256; i++) drive(i << 8, "R2 table point");
        idle(3);

        // R1 field boundaries and quadrant seams, last index at full fraction
        drive(18'h00000, "R1 origin");
        drive(18'h000FF, "R1 fraction only");
        drive(18'h0FF00, "R1 last index");
        drive(18'h0FFFF, "R6 top of quarter");
        drive(18'h10000, "R4 seam q1");
        drive(18'h1FFFF, "R4 end q1");
        drive(18'h20000, "R5 seam q2");
        drive(18'h2FFFF, "R5 end q2");
        drive(18'h30000, "R5 seam q3");
        drive(18'h3FFFF, "R5 end q3");
        drive(18'h10080, "R4 mirror mid");
        idle(5);

        // strided sweep of the full circle
        for (int ph = 0; ph < 262144; ph += 13) drive(ph, tag_for(ph));
        idle(4);

        // pseudo-random phases with random idle gaps
        lfsr = 32'h1ACE5;
        for (int k = 0; k < 4000; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            drive(lfsr & 18'h3FFFF, tag_for(lfsr & 18'h3FFFF));
            if (((lfsr >> 20) & 3) == 0) idle(((lfsr >> 22) & 3) + 1);
        end
        idle(8);
        check(q_exp.size() == 0, "R7 all results delivered", q_exp.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule